// File: doc/BRIEF.md
# Configurable Crosspoint Transfer Port

This block is a single crosspoint between one producing unit and one consuming unit. It works in one of two transfer styles. In buffered mode, an eight-entry queue separates the two sides, so the producer can run ahead of the consumer. In rendezvous mode, the port holds no words. A word passes from producer to consumer only in a cycle where both sides present a request.

Each side also has its own protocol choice. A blocking side waits until its access can really take place: space is free, data is present, or the partner side is present. A non-blocking side always completes its access at once. When that access cannot take place, a lost write raises a sticky overflow flag. A starved read returns the last delivered word and raises a sticky underflow flag. A requested change of transfer style takes effect only when the queue is empty.

Top module: `xpt_port`

## Requirements
- R1: In buffered mode (`mode_act`=0), accepted words come out in the order they were written, and the queue accepts up to 8 words before it counts as full.
- R2: A blocking write (`wr_blk`=1) to a full queue gets `wr_ack`=0. A blocking read (`rd_blk`=1) from an empty queue gets `rd_ack`=0. Neither access changes the queue.
- R3: A non-blocking write to a full queue gets `wr_ack`=1. The word is discarded, and `ovf` reads 1 from the next cycle until reset.
- R4: A non-blocking read from an empty queue gets `rd_ack`=1. `rd_data` equals the last word delivered (0 after reset), and `udf` reads 1 from the next cycle until reset.
- R5: In buffered mode, when the queue is neither empty nor full, a write and a read in the same cycle are both acknowledged. The read returns the oldest word, and the written word joins the back of the queue.
- R6: In rendezvous mode (`mode_act`=1), when both `wr_valid` and `rd_valid` are high, both are acknowledged in that cycle and `rd_data` equals `wr_data`. Nothing is stored.
- R7: In rendezvous mode, a blocking side whose partner is absent is not acknowledged. A non-blocking side whose partner is absent is acknowledged. An unmatched write then sets `ovf`. An unmatched read returns the last delivered word and sets `udf`.
- R8: `mode_sel` (0 = buffered, 1 = rendezvous) is copied to `mode_act` at a clock edge only when the queue is empty and no word enters it in that cycle. Otherwise the change waits until the queue has drained.
- R9: A synchronous reset (`rst`=1) empties the queue, clears `ovf`, `udf` and the last-delivered word, and selects buffered mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 1 | Requested transfer style: 0 buffered, 1 rendezvous |
| wr_blk | input | 1 | Producer protocol: 1 blocking, 0 non-blocking |
| rd_blk | input | 1 | Consumer protocol: 1 blocking, 0 non-blocking |
| wr_valid | input | 1 | Producer offers a word |
| wr_data | input | W | Producer word |
| wr_ack | output | 1 | Producer access completes this cycle |
| rd_valid | input | 1 | Consumer requests a word |
| rd_data | output | W | Word delivered to the consumer |
| rd_ack | output | 1 | Consumer access completes this cycle |
| mode_act | output | 1 | Transfer style currently in force |
| ovf | output | 1 | Sticky lost-write flag |
| udf | output | 1 | Sticky starved-read flag |

## Verification
Two functions can fall in the same cycle. The first pair is a producer push and a consumer pop on a partly filled queue. The second pair is a pending style change and a word entering an empty queue. The bench provokes the first by asserting both requests for several cycles while the queue holds between one and seven words. It provokes the second by raising `mode_sel` while words are still queued and then draining them. A reference model in the bench predicts, cycle by cycle, the acknowledgements, the delivered word and `mode_act`. From these it judges that no word is lost or reordered and that the style switches only on the cycle after the queue empties.

// File: rtl/xpt_port.sv
module xpt_port #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_sel,
  input  logic         wr_blk,
  input  logic         rd_blk,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  output logic         wr_ack,
  input  logic         rd_valid,
  output logic [W-1:0] rd_data,
  output logic         rd_ack,
  output logic         mode_act,
  output logic         ovf,
  output logic         udf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, cnt_n;
  logic          full_q, empty_q, mode_q, ovf_q, udf_q;
  logic [W-1:0]  last_q;
  logic          fire, push, pop, drop_w, starve_r;

  assign fire  = mode_q & wr_valid & rd_valid;
  assign push  = ~mode_q & wr_valid & ~full_q;
  assign pop   = ~mode_q & rd_valid & ~empty_q;
  assign cnt_n = cnt + CW'(push) - CW'(pop);

  assign wr_ack = mode_q ? (wr_valid & (rd_valid | ~wr_blk))
                         : (wr_valid & (~full_q | ~wr_blk));
  assign rd_ack = mode_q ? (rd_valid & (wr_valid | ~rd_blk))
                         : (rd_valid & (~empty_q | ~rd_blk));

  assign rd_data = fire ? wr_data : (pop ? mem[rp] : last_q);

  assign drop_w   = wr_valid & ~wr_blk & (mode_q ? ~rd_valid : full_q);
  assign starve_r = rd_valid & ~rd_blk & (mode_q ? ~wr_valid : empty_q);

  assign mode_act = mode_q;
  assign ovf      = ovf_q;
  assign udf      = udf_q;

  always_ff @(posedge clk)
    if (push) mem[wp] <= wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      mode_q  <= 1'b0;
      ovf_q   <= 1'b0;
      udf_q   <= 1'b0;
      last_q  <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt     <= cnt_n;
      full_q  <= (cnt_n == CW'(DEPTH));
      empty_q <= (cnt_n == '0);
      if (fire | pop)       last_q <= rd_data;
      if (drop_w)           ovf_q  <= 1'b1;
      if (starve_r)         udf_q  <= 1'b1;
      if (empty_q & ~push)  mode_q <= mode_sel;
    end
  end
endmodule

// File: rtl/xpt_port_chk.sv
module xpt_port_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         mode_act,
  input logic         wr_blk,
  input logic         rd_blk,
  input logic         wr_valid,
  input logic [W-1:0] wr_data,
  input logic         wr_ack,
  input logic         rd_valid,
  input logic [W-1:0] rd_data,
  input logic         rd_ack,
  input logic         ovf,
  input logic         udf,
  input logic         full_q,
  input logic         empty_q
);
  // R2
  blk_wr_full_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_act && wr_blk && full_q) |-> !wr_ack);
  // R2
  blk_rd_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_act && rd_blk && empty_q) |-> !rd_ack);
  // R3
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
  // R4
  udf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    udf |=> udf);
  // R6
  rdv_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_act && wr_valid && rd_valid) |-> (wr_ack && rd_ack && rd_data == wr_data));
  // R7
  sync_blk_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_act && wr_blk && !rd_valid) |-> !wr_ack);
  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !empty_q |=> $stable(mode_act));
  // R1
  flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(full_q && empty_q));
endmodule

bind xpt_port xpt_port_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .mode_act(mode_act), .wr_blk(wr_blk), .rd_blk(rd_blk),
  .wr_valid(wr_valid), .wr_data(wr_data), .wr_ack(wr_ack),
  .rd_valid(rd_valid), .rd_data(rd_data), .rd_ack(rd_ack),
  .ovf(ovf), .udf(udf), .full_q(full_q), .empty_q(empty_q)
);

// File: tb/xpt_port_tb_top.sv
module xpt_port_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_sel = 1'b0, wr_blk = 1'b1, rd_blk = 1'b1;
  logic wr_valid = 1'b0, rd_valid = 1'b0;
  logic [15:0] wr_data = '0;
  logic wr_ack, rd_ack, mode_act, ovf, udf;
  logic [15:0] rd_data;

  always #5 clk = ~clk;

  xpt_port #(.W(16), .DEPTH(8)) dut_i (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .wr_blk(wr_blk), .rd_blk(rd_blk),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ack(wr_ack),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_ack(rd_ack),
    .mode_act(mode_act), .ovf(ovf), .udf(udf)
  );

  typedef struct {
    logic        wa, ra, chkd, ov, ud, md;
    logic [15:0] d;
    string       tag;
  } item_t;

  item_t       scb[$];
  logic [15:0] mq[$];
  logic        e_ovf, e_udf, e_mode;
  logic [15:0] e_last;
  int          vecs = 0, errs = 0;
  bit          done = 0;

  task automatic model_clear();
    mq.delete();
    e_ovf = 0; e_udf = 0; e_mode = 0; e_last = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_valid = 1'b0; rd_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_clear();
  endtask

  task automatic step(input logic wv, input logic [15:0] wd, input logic rv, input string tag);
    item_t it;
    int    n;
    logic  acc, pp, fire;
    n = mq.size();
    wr_valid = wv; wr_data = wd; rd_valid = rv;
    it.ov = e_ovf; it.ud = e_udf; it.md = e_mode; it.tag = tag;
    acc = 0;
    if (e_mode) begin
      fire  = wv && rv;
      it.wa = wv && (rv || !wr_blk);
      it.ra = rv && (wv || !rd_blk);
      it.d  = fire ? wd : e_last;
      if (fire) e_last = wd;
      if (wv && !rv && !wr_blk) e_ovf = 1;
      if (rv && !wv && !rd_blk) e_udf = 1;
    end else begin
      acc   = wv && (n < 8);
      pp    = rv && (n > 0);
      it.wa = wv && ((n < 8) || !wr_blk);
      it.ra = rv && ((n > 0) || !rd_blk);
      it.d  = pp ? mq[0] : e_last;
      if (pp) begin e_last = mq[0]; void'(mq.pop_front()); end
      if (acc) mq.push_back(wd);
      if (wv && n == 8 && !wr_blk) e_ovf = 1;
      if (rv && n == 0 && !rd_blk) e_udf = 1;
    end
    it.chkd = it.ra;
    if (n == 0 && !acc) e_mode = mode_sel;
    scb.push_back(it);
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    item_t it;
    #3;
    if (scb.size() > 0) begin
      it = scb.pop_front();
      vecs++;
      if (wr_ack !== it.wa || rd_ack !== it.ra || mode_act !== it.md ||
          ovf !== it.ov || udf !== it.ud || (it.chkd && rd_data !== it.d)) begin
        errs++;
        $display("FAIL %s: act wa=%b ra=%b md=%b ov=%b ud=%b d=%h exp wa=%b ra=%b md=%b ov=%b ud=%b d=%h",
                 it.tag, wr_ack, rd_ack, mode_act, ovf, udf, rd_data,
                 it.wa, it.ra, it.md, it.ov, it.ud, it.d);
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: act running exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    do_reset();
    step(0, 16'h0, 0, "R9 reset state");
    // R2 blocking read from empty
    step(0, 16'h0, 1, "R2 blocking read empty");
    // R4 non-blocking read from empty returns 0 after reset
    rd_blk = 0;
    step(0, 16'h0, 1, "R4 starved read");
    step(0, 16'h0, 0, "R4 udf sticky");
    rd_blk = 1;
    // R1 fill to depth
    for (int i = 0; i < 8; i++) step(1, 16'hA000 + 16'(i), 0, "R1 fill");
    step(1, 16'hBEEF, 0, "R2 blocking write full");
    wr_blk = 0;
    step(1, 16'hDEAD, 0, "R3 dropped write");
    step(0, 16'h0, 0, "R3 ovf sticky");
    wr_blk = 1;
    // R8 request deferred while queue holds data
    mode_sel = 1;
    for (int i = 0; i < 3; i++) step(0, 16'h0, 1, "R8 deferred drain R1");
    // R5 concurrent read and write
    for (int i = 0; i < 4; i++) step(1, 16'hC000 + 16'(i), 1, "R5 concurrent");
    mode_sel = 0;
    for (int i = 0; i < 9; i++) step(0, 16'h0, 1, "R1 drain order");
    rd_blk = 0;
    step(0, 16'h0, 1, "R4 last value returned");
    rd_blk = 1;
    // R8 switch while empty and a word entering the same cycle
    mode_sel = 1;
    step(1, 16'h1111, 0, "R8 write blocks switch");
    step(0, 16'h0, 1, "R8 drain");
    step(0, 16'h0, 0, "R8 switch now");
    step(0, 16'h0, 0, "R8 sync active");
    // R9 reset clears flags, then sync tests
    do_reset();
    step(0, 16'h0, 0, "R9 flags cleared");
    step(0, 16'h0, 0, "R8 enter sync");
    for (int i = 0; i < 4; i++) step(1, 16'h5000 + 16'(i), 1, "R6 rendezvous");
    step(1, 16'h7777, 0, "R7 blocking writer waits");
    step(0, 16'h0, 1, "R7 blocking reader waits");
    rd_blk = 0;
    step(0, 16'h0, 1, "R7 unmatched read");
    wr_blk = 0;
    step(1, 16'h6666, 0, "R7 unmatched write");
    step(1, 16'h4242, 1, "R6 rendezvous nonblocking");
    step(0, 16'h0, 0, "R7 flags sticky");
    wr_blk = 1; rd_blk = 1;
    mode_sel = 0;
    step(0, 16'h0, 0, "R8 back to buffered");
    step(1, 16'h9999, 0, "R1 buffered again");
    step(0, 16'h0, 1, "R1 buffered read");
    do_reset();
    step(0, 16'h0, 0, "R9 final reset state");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule